// File: doc/BRIEF.md
# Predicted-Reference Read-Retry Controller

This block sits between a host read port and a flash read/ECC handshake. It holds one learned read reference code for each flash block, shared by every page of that block. A host read starts from that stored code. Each time ECC reports the data as uncorrectable, the block lowers the code by a fixed step and reissues the read. It gives up after a set number of retries.

A periodic trigger starts a background refresh pass. The pass visits every block in order. For each block it reads a short window of codes, stepping down from the current prediction, and stores the code with the fewest ECC errors as the new prediction. Host reads always win the single flash port. While a host read is waiting, the pass holds after its current read and resumes once the host read has finished.

Top module: `pref_retry_ctrl`

## Requirements
- R1: After reset every table entry holds DEF_REF, `host_ready_o` is 1, and `fl_req_o`, `host_done_o` and `sweep_busy_o` are 0.
- R2: The first flash read of a host request uses the stored prediction of the requested block.
- R3: After a read with `ecc_ok_i`=0, the next read of the same request uses the previous code minus STEP, saturating at 0. A read at code 0 is therefore repeated at 0.
- R4: A read with `ecc_ok_i`=1 ends the request. `host_done_o` pulses for one cycle, with `host_ok_o`=1, `host_retries_o` equal to the number of failed reads, and `host_ref_o` equal to the successful code.
- R5: When MAX_RETRY retries have all failed, the request ends with `host_ok_o`=0 and `host_retries_o`=MAX_RETRY, after MAX_RETRY+1 reads.
- R6: A pulse on `refresh_tick_i` while idle starts a pass and raises `sweep_busy_o`. The pass covers blocks 0 to NUM_BLK-1. For each block it reads the codes pred, pred-STEP, and so on. It stops after WIN_STEPS reads, or earlier once a read at code 0 has been made.
- R7: At the end of each block's window, the code with the lowest `ecc_err_cnt_i` becomes that block's prediction. On equal counts the code read earlier wins. Later host reads of that block start from the new code.
- R8: Host reads have priority. When the flash port is free and both sides want it, the host read is granted. A host request made during a pass completes after at most the remaining sweep read plus its own reads.
- R9: `fl_req_o` stays high, with `fl_blk_o` and `fl_ref_o` stable, until `fl_ack_i`. Only one read is outstanding at a time.
- R10: `refresh_tick_i` pulses during a running pass are ignored and do not start a second pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Read request, taken when host_ready_o is 1 |
| host_blk_i | input | BLK_W | Flash block of the request |
| host_ready_o | output | 1 | No host request in progress |
| host_done_o | output | 1 | One-cycle completion pulse |
| host_ok_o | output | 1 | Last request decoded successfully |
| host_retries_o | output | CNT_W | Retries used by last request |
| host_ref_o | output | 8 | Code of the last read of the request |
| refresh_tick_i | input | 1 | Periodic trigger for a refresh pass |
| sweep_busy_o | output | 1 | Refresh pass running |
| fl_req_o | output | 1 | Flash read request, held until ack |
| fl_blk_o | output | BLK_W | Block of the flash read |
| fl_ref_o | output | 8 | Reference code of the flash read |
| fl_ack_i | input | 1 | Read and ECC result valid, one cycle |
| ecc_ok_i | input | 1 | ECC corrected the data |
| ecc_err_cnt_i | input | ERR_W | ECC error count of the read |

## Verification
The assertions assume that the flash side raises `fl_ack_i` only while `fl_req_o` is high, for a single cycle per read. They also assume that the host raises `host_req_i` only while `host_ready_o` is high. The bench flash model meets the first assumption by counting a fixed latency from each new request and dropping the ack on the next cycle. The host tasks meet the second by pulsing a request for one cycle and then waiting for the done pulse before issuing another.

// File: rtl/pref_retry_pkg.sv
package pref_retry_pkg;
  typedef logic [7:0] ref_t;
  typedef enum logic {OWN_HOST = 1'b0, OWN_SWEEP = 1'b1} owner_e;

  function automatic ref_t ref_down(ref_t code, ref_t step);
    return (code > step) ? ref_t'(code - step) : '0;
  endfunction
endpackage

// File: rtl/pref_table.sv
module pref_table #(
  parameter int NUM_BLK = 64,
  parameter int DEF_REF = 20,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] rd0_blk_i,
  output logic [7:0]       rd0_ref_o,
  input  logic [BLK_W-1:0] rd1_blk_i,
  output logic [7:0]       rd1_ref_o,
  input  logic             wr_en_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic [7:0]       wr_ref_i
);
  logic [7:0] ent_q [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[g] <= 8'(DEF_REF);
      else if (wr_en_i && wr_blk_i == BLK_W'(g))    ent_q[g] <= wr_ref_i;
    end
  end

  assign rd0_ref_o = ent_q[rd0_blk_i];
  assign rd1_ref_o = ent_q[rd1_blk_i];
endmodule

// File: rtl/pref_retry_seq.sv
module pref_retry_seq
  import pref_retry_pkg::*;
#(
  parameter int BLK_W     = 6,
  parameter int STEP      = 8,
  parameter int MAX_RETRY = 4,
  localparam int CNT_W = $clog2(MAX_RETRY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_req_i,
  input  logic [BLK_W-1:0] host_blk_i,
  output logic             host_ready_o,
  input  ref_t             pred_ref_i,
  output logic             rd_req_o,
  output logic [BLK_W-1:0] rd_blk_o,
  output ref_t             rd_ref_o,
  input  logic             rd_ack_i,
  input  logic             ecc_ok_i,
  output logic             done_o,
  output logic             ok_o,
  output logic [CNT_W-1:0] retries_o,
  output ref_t             ref_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign host_ready_o = !run_q;
  assign rd_req_o     = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      rd_blk_o  <= '0;
      rd_ref_o  <= '0;
      done_o    <= 1'b0;
      ok_o      <= 1'b0;
      retries_o <= '0;
      ref_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (!run_q) begin
        if (host_req_i) begin
          run_q    <= 1'b1;
          cnt_q    <= '0;
          rd_blk_o <= host_blk_i;
          rd_ref_o <= pred_ref_i;
        end
      end else if (rd_ack_i) begin
        if (ecc_ok_i || cnt_q == CNT_W'(MAX_RETRY)) begin
          run_q     <= 1'b0;
          done_o    <= 1'b1;
          ok_o      <= ecc_ok_i;
          retries_o <= cnt_q;
          ref_o     <= rd_ref_o;
        end else begin
          cnt_q    <= cnt_q + 1'b1;
          rd_ref_o <= ref_down(rd_ref_o, 8'(STEP));
        end
      end
    end
  end
endmodule

// File: rtl/pref_sweep.sv
module pref_sweep
  import pref_retry_pkg::*;
#(
  parameter int NUM_BLK   = 64,
  parameter int STEP      = 8,
  parameter int WIN_STEPS = 4,
  parameter int ERR_W     = 8,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int K_W   = $clog2(WIN_STEPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             busy_o,
  output logic [BLK_W-1:0] pred_blk_o,
  input  ref_t             pred_ref_i,
  output logic             rd_req_o,
  output ref_t             rd_ref_o,
  input  logic             rd_ack_i,
  input  logic [ERR_W-1:0] err_cnt_i,
  output logic             wr_en_o,
  output ref_t             wr_ref_o
);
  typedef enum logic [1:0] {SW_IDLE, SW_LOAD, SW_READ} sw_e;
  sw_e              st_q;
  logic [BLK_W-1:0] blk_q;
  logic [K_W-1:0]   k_q;
  ref_t             best_q;
  logic [ERR_W-1:0] best_err_q;
  logic             take, last;

  assign busy_o     = st_q != SW_IDLE;
  assign pred_blk_o = blk_q;
  assign rd_req_o   = st_q == SW_READ;
  // strict compare keeps the earlier code on a tie
  assign take       = (k_q == '0) || (err_cnt_i < best_err_q);
  assign last       = (k_q == K_W'(WIN_STEPS - 1)) || (rd_ref_o == '0);
  assign wr_en_o    = rd_req_o && rd_ack_i && last;
  assign wr_ref_o   = take ? rd_ref_o : best_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SW_IDLE;
      blk_q      <= '0;
      k_q        <= '0;
      rd_ref_o   <= '0;
      best_q     <= '0;
      best_err_q <= '0;
    end else begin
      unique case (st_q)
        SW_IDLE: if (tick_i) begin
          st_q  <= SW_LOAD;
          blk_q <= '0;
        end
        SW_LOAD: begin
          st_q     <= SW_READ;
          k_q      <= '0;
          rd_ref_o <= pred_ref_i;
        end
        SW_READ: if (rd_ack_i) begin
          if (take) begin
            best_q     <= rd_ref_o;
            best_err_q <= err_cnt_i;
          end
          if (last) begin
            if (blk_q == BLK_W'(NUM_BLK - 1)) st_q <= SW_IDLE;
            else begin
              st_q  <= SW_LOAD;
              blk_q <= blk_q + 1'b1;
            end
          end else begin
            k_q      <= k_q + 1'b1;
            rd_ref_o <= ref_down(rd_ref_o, 8'(STEP));
          end
        end
        default: st_q <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pref_retry_ctrl.sv
module pref_retry_ctrl
  import pref_retry_pkg::*;
#(
  parameter int NUM_BLK   = 64,
  parameter int DEF_REF   = 20,
  parameter int STEP      = 8,
  parameter int MAX_RETRY = 4,
  parameter int WIN_STEPS = 4,
  parameter int ERR_W     = 8,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int CNT_W = $clog2(MAX_RETRY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_req_i,
  input  logic [BLK_W-1:0] host_blk_i,
  output logic             host_ready_o,
  output logic             host_done_o,
  output logic             host_ok_o,
  output logic [CNT_W-1:0] host_retries_o,
  output logic [7:0]       host_ref_o,
  input  logic             refresh_tick_i,
  output logic             sweep_busy_o,
  output logic             fl_req_o,
  output logic [BLK_W-1:0] fl_blk_o,
  output logic [7:0]       fl_ref_o,
  input  logic             fl_ack_i,
  input  logic             ecc_ok_i,
  input  logic [ERR_W-1:0] ecc_err_cnt_i
);
  ref_t             h_pred, s_pred, h_ref, s_ref, s_wr_ref;
  logic [BLK_W-1:0] h_blk, s_blk;
  logic             h_req, s_req, h_ack, s_ack, s_wr_en;
  logic             busy_q;
  owner_e           owner_q;

  pref_table #(.NUM_BLK(NUM_BLK), .DEF_REF(DEF_REF)) u_table (
    .clk_i, .rst_ni,
    .rd0_blk_i(host_blk_i), .rd0_ref_o(h_pred),
    .rd1_blk_i(s_blk),      .rd1_ref_o(s_pred),
    .wr_en_i(s_wr_en), .wr_blk_i(s_blk), .wr_ref_i(s_wr_ref)
  );

  pref_retry_seq #(.BLK_W(BLK_W), .STEP(STEP), .MAX_RETRY(MAX_RETRY)) u_seq (
    .clk_i, .rst_ni,
    .host_req_i, .host_blk_i, .host_ready_o,
    .pred_ref_i(h_pred),
    .rd_req_o(h_req), .rd_blk_o(h_blk), .rd_ref_o(h_ref),
    .rd_ack_i(h_ack), .ecc_ok_i,
    .done_o(host_done_o), .ok_o(host_ok_o), .retries_o(host_retries_o), .ref_o(host_ref_o)
  );

  pref_sweep #(.NUM_BLK(NUM_BLK), .STEP(STEP), .WIN_STEPS(WIN_STEPS), .ERR_W(ERR_W)) u_sweep (
    .clk_i, .rst_ni,
    .tick_i(refresh_tick_i), .busy_o(sweep_busy_o),
    .pred_blk_o(s_blk), .pred_ref_i(s_pred),
    .rd_req_o(s_req), .rd_ref_o(s_ref), .rd_ack_i(s_ack),
    .err_cnt_i(ecc_err_cnt_i),
    .wr_en_o(s_wr_en), .wr_ref_o(s_wr_ref)
  );

  // single flash port, host first; grant only while no read is outstanding
  assign fl_req_o = busy_q;
  assign h_ack    = busy_q && fl_ack_i && owner_q == OWN_HOST;
  assign s_ack    = busy_q && fl_ack_i && owner_q == OWN_SWEEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      owner_q  <= OWN_HOST;
      fl_blk_o <= '0;
      fl_ref_o <= '0;
    end else if (busy_q) begin
      if (fl_ack_i) busy_q <= 1'b0;
    end else if (h_req) begin
      busy_q   <= 1'b1;
      owner_q  <= OWN_HOST;
      fl_blk_o <= h_blk;
      fl_ref_o <= h_ref;
    end else if (s_req) begin
      busy_q   <= 1'b1;
      owner_q  <= OWN_SWEEP;
      fl_blk_o <= s_blk;
      fl_ref_o <= s_ref;
    end
  end
endmodule

// File: rtl/pref_retry_checker.sv
module pref_retry_checker #(
  parameter int MAX_RETRY = 4,
  parameter int BLK_W     = 6,
  parameter int CNT_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_req_i,
  input logic             host_ready_o,
  input logic             host_done_o,
  input logic             host_ok_o,
  input logic [CNT_W-1:0] host_retries_o,
  input logic             refresh_tick_i,
  input logic             sweep_busy_o,
  input logic             fl_req_o,
  input logic [BLK_W-1:0] fl_blk_o,
  input logic [7:0]       fl_ref_o,
  input logic             fl_ack_i
);
  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o && !fl_ack_i |=> fl_req_o && $stable(fl_blk_o) && $stable(fl_ref_o));
  a_r9_ack_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_ack_i |-> fl_req_o);
  a_r5_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |-> host_retries_o <= CNT_W'(MAX_RETRY));
  a_r5_fail_uses_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o && !host_ok_o |-> host_retries_o == CNT_W'(MAX_RETRY));
  a_r4_done_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |-> host_ready_o);
  a_r6_pass_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sweep_busy_o) |-> $past(refresh_tick_i));
  a_r4_req_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && host_ready_o |=> !host_ready_o);
endmodule

bind pref_retry_ctrl pref_retry_checker #(
  .MAX_RETRY(MAX_RETRY), .BLK_W(BLK_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .host_req_i, .host_ready_o, .host_done_o, .host_ok_o,
  .host_retries_o, .refresh_tick_i, .sweep_busy_o, .fl_req_o, .fl_blk_o,
  .fl_ref_o, .fl_ack_i
);

// File: tb/pref_retry_ctrl_bench.sv
`timescale 1ns/100ps
module pref_retry_ctrl_bench;
  localparam int NB = 8, STEP = 8, MR = 4, WS = 4, DEF = 20, LAT = 2;
  localparam int BW = 3, CW = 3;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, tick = 0;
  logic [BW-1:0] host_blk = '0;
  logic host_ready, host_done, host_ok, sweep_busy, fl_req;
  logic [CW-1:0] host_ret;
  logic [7:0] host_ref, fl_ref;
  logic [BW-1:0] fl_blk;
  logic fl_ack = 0, ecc_ok = 0;
  logic [7:0] ecc_err = '0;

  int errors = 0, checks = 0;
  int thr [NB], opt [NB];
  bit never [NB];
  int nreads = 0;
  int rlog [64];
  int wait_c = 0;

  always #2.5 clk = ~clk;

  pref_retry_ctrl #(.NUM_BLK(NB), .DEF_REF(DEF), .STEP(STEP), .MAX_RETRY(MR),
                    .WIN_STEPS(WS), .ERR_W(8)) u_pref_retry_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_blk_i(host_blk), .host_ready_o(host_ready),
    .host_done_o(host_done), .host_ok_o(host_ok), .host_retries_o(host_ret),
    .host_ref_o(host_ref), .refresh_tick_i(tick), .sweep_busy_o(sweep_busy),
    .fl_req_o(fl_req), .fl_blk_o(fl_blk), .fl_ref_o(fl_ref),
    .fl_ack_i(fl_ack), .ecc_ok_i(ecc_ok), .ecc_err_cnt_i(ecc_err)
  );

  // flash + ECC model, driven away from the active edge
  always @(negedge clk) begin
    if (fl_ack) fl_ack = 0;
    else if (fl_req) begin
      if (wait_c == LAT) begin
        int r, b, d;
        r = int'(fl_ref); b = int'(fl_blk);
        d = (r > opt[b]) ? r - opt[b] : opt[b] - r;
        fl_ack  = 1;
        ecc_ok  = !never[b] && (r <= thr[b]);
        ecc_err = 8'(d);
        rlog[nreads % 64] = r;
        nreads++;
        wait_c = 0;
      end else wait_c++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_read(input int blk, output int ok, output int ret,
                           output int rf, output int cyc);
    @(negedge clk);
    host_blk = BW'(blk);
    host_req = 1;
    @(negedge clk);
    host_req = 0;
    cyc = 1;
    while (!host_done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    ok = int'(host_ok); ret = int'(host_ret); rf = int'(host_ref);
  endtask

  // blk, thr, never, exp_ok, exp_retries, exp_ref
  localparam int VEC [4][6] = '{
    '{1, 255, 0, 1, 0, 20},
    '{2,  10, 0, 1, 2,  4},
    '{3,   0, 0, 1, 3,  0},
    '{4,   0, 1, 0, 4,  0}
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ok, ret, rf, cyc, n0;
    for (int i = 0; i < NB; i++) begin thr[i] = 255; opt[i] = 20; never[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(host_ready), 1);
    chk("R1 fl_req", int'(fl_req), 0);
    chk("R1 busy", int'(sweep_busy), 0);
    chk("R1 done", int'(host_done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      thr[VEC[v][0]] = VEC[v][1];
      never[VEC[v][0]] = VEC[v][2] != 0;
      n0 = nreads;
      host_read(VEC[v][0], ok, ret, rf, cyc);
      chk("R2 first ref from table (R1 default)", rlog[n0 % 64], DEF);
      chk("R4/R5 ok", ok, VEC[v][3]);
      chk("R4/R5 retries", ret, VEC[v][4]);
      chk("R3 final ref", rf, VEC[v][5]);
      chk("R5 read count", nreads - n0, VEC[v][4] + 1);
    end
    // R3 saturation: last vector read 20,12,4,0,0
    chk("R3 sat step", rlog[(nreads - 2) % 64], 0);
    chk("R3 sat step", rlog[(nreads - 3) % 64], 4);

    // background pass
    for (int i = 0; i < NB; i++) begin thr[i] = 255; never[i] = 0; end
    opt[0] = 12; opt[1] = 16; opt[2] = 0;
    n0 = nreads;
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    chk("R6 busy", int'(sweep_busy), 1);
    repeat (5) @(negedge clk);
    tick = 1; @(negedge clk); tick = 0;  // R10 ignored mid-pass
    while (nreads - n0 < 10) @(negedge clk);
    host_read(7, ok, ret, rf, cyc);
    chk("R8 host served promptly", int'(cyc <= 16), 1);
    chk("R8 host ok", ok, 1);
    cyc = 0;
    while (sweep_busy && cyc < 5000) begin @(negedge clk); cyc++; end
    chk("R6 read count", nreads - n0, NB * WS + 1);
    n0 = nreads;
    repeat (60) @(negedge clk);
    chk("R10 no second pass", int'(sweep_busy), 0);
    chk("R10 no reads", nreads - n0, 0);

    host_read(0, ok, ret, rf, cyc);
    chk("R7 best code blk0", rf, 12);
    host_read(1, ok, ret, rf, cyc);
    chk("R7 tie keeps earlier", rf, 20);
    host_read(2, ok, ret, rf, cyc);
    chk("R7 best at zero", rf, 0);
    host_read(5, ok, ret, rf, cyc);
    chk("R7 unchanged blk5", rf, 20);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule